// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block counts ticks from one of three sources and asks for a reset when software fails to clear it in time. The sources are a strobe from a dedicated RC oscillator, a strobe from a real-time-clock oscillator, and an internal instruction tick at one quarter of the system clock. The oscillators sit outside the block and reach it only as one-cycle enable strobes. The chosen tick feeds a fixed 256-step divider. A prescaler follows the divider and stretches the period by a power of two that software selects.

An 8-bit control register holds the prescaler select in its three low bits. Its upper five bits are free flags for software. The counter is cleared by an external reset, by a halt instruction, or by clear instructions. A static input picks how many clear instructions are needed. In single mode one general clear instruction is enough. In dual mode two distinct clear instructions are needed, and they may arrive in either order.

When the count expires, the block raises one of two reset requests. If the core is running, it asks for a full chip reset. If the core is halted, it asks for a warm reset. The control logic is built from two small state machines:
- The pairing machine has the states PAIR_NONE, PAIR_GOT_A and PAIR_GOT_B. It moves PAIR_NONE→PAIR_GOT_A on clear-A alone and PAIR_NONE→PAIR_GOT_B on clear-B alone. It returns to PAIR_NONE when the pair completes, or on any other counter clear or overflow.
- The request machine has the states EV_QUIET, EV_CHIP and EV_WARM. It moves EV_QUIET→EV_CHIP on an overflow while running and EV_QUIET→EV_WARM on an overflow while halted. Each request state always returns to EV_QUIET after one cycle.

Top module: `wdt_core`

## Requirements
- R1: While reset is held and just after it, the following holds: reg_rdata reads 8'h07, to_flag is 0, and neither request output is asserted.
- R2: Let s be the prescaler select in reg_rdata[2:0]. The request is asserted on the cycle after the (256·2^s)-th selected tick that follows a counter clear. The counter then restarts from zero, so requests repeat every 256·2^s ticks.
- R3: Bits 7:3 of the control register read back exactly as written and do not change the timeout period.
- R4: cfg_src selects the tick source: 2'b00 picks rc_tick, 2'b01 picks rtc_tick, and 2'b10 or 2'b11 picks the instruction tick. The instruction tick fires once every 4 clocks. A strobe on a source that is not selected has no effect.
- R5: In single-clear mode (cfg_dual_clear=0), a clr_all pulse clears the counter and the prescaler. In this mode clr_a and clr_b are ignored, even when they come together.
- R6: In dual-clear mode (cfg_dual_clear=1), the counter is cleared only once both clr_a and clr_b have been seen, in either order. Repeating the same one does not complete the pair, and clr_all is ignored. The memory of a half pair is dropped whenever the counter is cleared or overflows.
- R7: A halt_exec pulse clears the counter, the prescaler and to_flag.
- R8: An overflow while halted=0 gives a one-cycle chip_rst_req pulse and sets to_flag. An accepted clear instruction clears to_flag.
- R9: An overflow while halted=1 gives a one-cycle warm_rst_req pulse instead, and also sets to_flag.
- R10: With the instruction tick selected, the tick phase and the counter freeze while halted=1. The timeout is pushed back by exactly the number of halted cycles.
- R11: With cfg_enable=0, no request is ever raised, clears and halt_exec have no effect, and to_flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External asynchronous reset, active low |
| cfg_enable | input | 1 | Static watchdog enable |
| cfg_dual_clear | input | 1 | Static choice: 0 selects single-clear mode, 1 selects dual-clear mode |
| cfg_src | input | 2 | Static tick source select |
| rc_tick | input | 1 | Strobe from the RC oscillator |
| rtc_tick | input | 1 | Strobe from the real-time-clock oscillator |
| halted | input | 1 | Core is in the halt state |
| halt_exec | input | 1 | One-cycle pulse when a halt instruction executes |
| clr_all | input | 1 | Single clear instruction pulse |
| clr_a | input | 1 | First clear instruction of the pair |
| clr_b | input | 1 | Second clear instruction of the pair |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| to_flag | output | 1 | Timeout status flag |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request |

## Verification
The timing rules the checks rely on are these:
- A clear, halt_exec or reset release that is sampled at edge A restarts the count. The request then shows up just after edge A+N, where N is 256·2^s for the RC and RTC sources and 4·256·2^s for the instruction tick.
- Every halted cycle on the instruction tick adds exactly one edge to that figure.
- A register write and a to_flag update are visible just after the edge that samples them.

The driver computes each due cycle from these rules and pushes it into a queue. A monitor samples on the falling edge and pops one entry per request. It flags any request that comes early, late, of the wrong kind, or with no entry expected.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        SRC_RC    = 2'b00,
        SRC_RTC   = 2'b01,
        SRC_INSTR = 2'b10,
        SRC_INSTB = 2'b11
    } wdt_src_e;

    typedef enum logic [1:0] {
        PAIR_NONE  = 2'b00,
        PAIR_GOT_A = 2'b01,
        PAIR_GOT_B = 2'b10
    } pair_state_e;

    typedef enum logic [1:0] {
        EV_QUIET = 2'b00,
        EV_CHIP  = 2'b01,
        EV_WARM  = 2'b10
    } ev_state_e;

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
    import wdt_pkg::*;
#(
    parameter int INSTR_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       rc_tick,
    input  logic       rtc_tick,
    input  logic       halted,
    output logic       tick
);

    localparam int PH_W = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(INSTR_DIV - 1);

    logic [PH_W-1:0] phase;
    logic            instr_tick;

    // Instruction-tick phase: frozen while the core is halted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!halted) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    assign instr_tick = !halted && (phase == PH_LAST);

    always_comb begin
        unique case (src)
            SRC_RC:    tick = rc_tick;
            SRC_RTC:   tick = rtc_tick;
            SRC_INSTR: tick = instr_tick;
            SRC_INSTB: tick = instr_tick;
            default:   tick = 1'b0;
        endcase
    end

    // R10: the phase does not move while halted
    a_r10_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(phase));

endmodule

// File: rtl/wdt_pair_clear.sv
module wdt_pair_clear
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dual,
    input  logic clr_all,
    input  logic clr_a,
    input  logic clr_b,
    input  logic flush,
    output logic clear_hit
);

    pair_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PAIR_NONE;
        else        state <= nxt;
    end

    always_comb begin
        clear_hit = 1'b0;
        nxt       = state;
        if (!enable) begin
            nxt = PAIR_NONE;
        end else begin
            if (!dual) begin
                clear_hit = clr_all;
            end else begin
                unique case (state)
                    PAIR_NONE: begin
                        if (clr_a && clr_b) clear_hit = 1'b1;
                        else if (clr_a)     nxt = PAIR_GOT_A;
                        else if (clr_b)     nxt = PAIR_GOT_B;
                    end
                    PAIR_GOT_A: if (clr_b) clear_hit = 1'b1;
                    PAIR_GOT_B: if (clr_a) clear_hit = 1'b1;
                    default:    nxt = PAIR_NONE;
                endcase
            end
            if (clear_hit || flush) nxt = PAIR_NONE;
        end
    end

    // R6: a lone instruction completes a pair only if the other half was remembered
    a_r6_pair_needs_memory: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && clear_hit && !(clr_a && clr_b)) |-> (state != PAIR_NONE));

    // R6: the memory never survives a counter clear
    a_r6_memory_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_hit || flush) |=> (state == PAIR_NONE));

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int DIV_BITS = 8,
    parameter int SEL_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tick,
    input  logic                clear,
    input  logic [SEL_BITS-1:0] sel,
    output logic                ovf
);

    localparam int CNT_W = DIV_BITS + (1 << SEL_BITS) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term_mask;
    logic             terminal;

    // Divider bits plus the prescaler bits chosen by sel form the active span.
    always_comb begin
        term_mask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < DIV_BITS + int'(sel)) term_mask[i] = 1'b1;
        end
    end

    assign terminal = ((cnt & term_mask) == term_mask);
    assign ovf      = enable && tick && terminal && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || clear || ovf) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5, R6, R7: an accepted clear leaves the count at zero
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R11: a disabled watchdog holds its count at zero
    a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0));

    // R10: without a tick the count holds
    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick && !clear) |=> $stable(cnt));

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int          DIV_BITS   = 8,
    parameter int          SEL_BITS   = 3,
    parameter int          INSTR_DIV  = 4,
    parameter int          REG_W      = 8,
    parameter logic [7:0]  CTRL_RESET = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_dual_clear,
    input  logic [1:0]       cfg_src,
    input  logic             rc_tick,
    input  logic             rtc_tick,
    input  logic             halted,
    input  logic             halt_exec,
    input  logic             clr_all,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             to_flag,
    output logic             chip_rst_req,
    output logic             warm_rst_req
);

    logic [REG_W-1:0] ctrl_q;
    logic             tick_w;
    logic             pair_hit;
    logic             halt_clr;
    logic             clear_cnt;
    logic             ovf_w;
    ev_state_e        ev_state, ev_next;

    // Control register: low bits select the prescaler, the rest are free flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= REG_W'(CTRL_RESET);
        else if (reg_wr) ctrl_q <= reg_wdata;
    end
    assign reg_rdata = ctrl_q;

    assign halt_clr  = cfg_enable && halt_exec;
    assign clear_cnt = halt_clr || pair_hit;

    wdt_tick_sel #(.INSTR_DIV(INSTR_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (cfg_src),
        .rc_tick  (rc_tick),
        .rtc_tick (rtc_tick),
        .halted   (halted),
        .tick     (tick_w)
    );

    wdt_pair_clear u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .dual      (cfg_dual_clear),
        .clr_all   (clr_all),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .flush     (halt_clr || ovf_w),
        .clear_hit (pair_hit)
    );

    wdt_count #(.DIV_BITS(DIV_BITS), .SEL_BITS(SEL_BITS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg_enable),
        .tick   (tick_w),
        .clear  (clear_cnt),
        .sel    (ctrl_q[SEL_BITS-1:0]),
        .ovf    (ovf_w)
    );

    // Request machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_state <= EV_QUIET;
        else        ev_state <= ev_next;
    end

    // Request machine: next state
    always_comb begin
        ev_next = EV_QUIET;
        if (ovf_w) ev_next = halted ? EV_WARM : EV_CHIP;
    end

    // Request machine: outputs
    always_comb begin
        chip_rst_req = 1'b0;
        warm_rst_req = 1'b0;
        unique case (ev_state)
            EV_QUIET: ;
            EV_CHIP:  chip_rst_req = 1'b1;
            EV_WARM:  warm_rst_req = 1'b1;
            default:  ;
        endcase
    end

    // Timeout flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           to_flag <= 1'b0;
        else if (!cfg_enable) to_flag <= 1'b0;
        else if (ovf_w)       to_flag <= 1'b1;
        else if (clear_cnt)   to_flag <= 1'b0;
    end

    // R8: a chip request follows an overflow seen while running
    a_r8_chip_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> !$past(halted));

    // R9: a warm request follows an overflow seen while halted
    a_r9_warm_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |-> $past(halted));

    // R8, R9: requests are single-cycle and never both at once
    a_r8_chip_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req);
    a_r9_warm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |=> !warm_rst_req);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_rst_req && warm_rst_req));

    // R8: the flag rises only together with a request
    a_r8_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> (chip_rst_req || warm_rst_req));

    // R11: a disabled watchdog raises nothing
    a_r11_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_enable) |-> !(chip_rst_req || warm_rst_req || to_flag));

endmodule

// File: tb/tb_wdt_core.sv
module tb_wdt_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b1;
    logic       cfg_dual_clear = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic       rc_tick = 1'b1;
    logic       rtc_tick = 1'b0;
    logic       halted = 1'b0;
    logic       halt_exec = 1'b0;
    logic       clr_all = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       to_flag;
    logic       chip_rst_req;
    logic       warm_rst_req;

    wdt_core dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_dual_clear(cfg_dual_clear), .cfg_src(cfg_src),
        .rc_tick(rc_tick), .rtc_tick(rtc_tick), .halted(halted),
        .halt_exec(halt_exec), .clr_all(clr_all), .clr_a(clr_a),
        .clr_b(clr_b), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .to_flag(to_flag),
        .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req)
    );

    always #2 clk = ~clk;

    typedef struct {
        int unsigned due;
        bit          warm;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        e;
    int unsigned cyc = 0;
    int          checks = 0;
    int          fails = 0;
    int          n_ev = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp_v, cyc);
        end
    endtask

    task automatic expect_req(input int unsigned due, input bit warm, input string tag);
        exp_t x;
        x.due = due; x.warm = warm; x.tag = tag;
        sb_q.push_back(x);
    endtask

    // Monitor: pops one expected item per observed request
    always @(negedge clk) begin
        if (rst_n && (chip_rst_req || warm_rst_req)) begin
            n_ev++;
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R8/R9 unexpected request: actual chip=%0b warm=%0b at cycle %0d, expected none",
                         chip_rst_req, warm_rst_req, cyc);
            end else begin
                e = sb_q.pop_front();
                if (e.due != cyc || e.warm != warm_rst_req || chip_rst_req == warm_rst_req) begin
                    fails++;
                    $display("FAIL %s: actual cycle %0d warm=%0b, expected cycle %0d warm=%0b",
                             e.tag, cyc, warm_rst_req, e.due, e.warm);
                end
            end
        end else if (sb_q.size() > 0 && cyc > sb_q[0].due) begin
            e = sb_q.pop_front();
            checks++;
            fails++;
            $display("FAIL %s: actual no request, expected one at cycle %0d", e.tag, e.due);
        end
    end

    task automatic at_cyc(input int unsigned t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic rst_run(input bit en, input bit dual, input logic [1:0] src,
                           input bit rc, input bit rtc, output int unsigned c);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_enable = en; cfg_dual_clear = dual; cfg_src = src;
        rc_tick = rc; rtc_tick = rtc; halted = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        c = cyc;
    endtask

    task automatic set_reg(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // which: 0 clr_all, 1 clr_a, 2 clr_b, 3 clr_a+clr_b, 4 halt_exec
    task automatic pulse_at(input int unsigned t, input int which);
        at_cyc(t);
        case (which)
            0: clr_all = 1'b1;
            1: clr_a = 1'b1;
            2: clr_b = 1'b1;
            3: begin clr_a = 1'b1; clr_b = 1'b1; end
            default: halt_exec = 1'b1;
        endcase
        @(negedge clk);
        clr_all = 1'b0; clr_a = 1'b0; clr_b = 1'b0; halt_exec = 1'b0;
    endtask

    task automatic finish_run();
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++; fails++;
            $display("FAIL %s: actual no request, expected one at cycle %0d", e.tag, e.due);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            finish_run();
        end
    end

    initial begin
        int unsigned c;
        int          ev0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(reg_rdata == 8'h07, "R1 reg reset", reg_rdata, 8'h07);
        check(to_flag == 1'b0, "R1 flag reset", to_flag, 0);
        check(!chip_rst_req && !warm_rst_req, "R1 no request", {chip_rst_req, warm_rst_req}, 0);

        // R2, R3: sel 0 with flag bits set, periodic restart
        rst_run(1, 0, 2'b00, 1, 0, c);
        set_reg(8'hA8);
        check(reg_rdata == 8'hA8, "R3 flags readback", reg_rdata, 8'hA8);
        expect_req(c + 256, 0, "R2 R3 first timeout sel0");
        expect_req(c + 512, 0, "R2 restart after timeout");
        at_cyc(c + 300);
        check(to_flag == 1'b1, "R8 flag set on timeout", to_flag, 1);
        // R5: pair instructions ignored in single mode
        pulse_at(c + 530, 3);
        expect_req(c + 768, 0, "R5 clr_a/clr_b ignored");
        pulse_at(c + 800, 0);
        check(to_flag == 1'b0, "R8 flag cleared by clear", to_flag, 0);
        expect_req(c + 1057, 0, "R5 clr_all restarts count");
        at_cyc(c + 1070);

        // R2: sel 3
        rst_run(1, 0, 2'b00, 1, 0, c);
        set_reg(8'h03);
        expect_req(c + 2048, 0, "R2 timeout sel3");
        at_cyc(c + 2060);

        // R9, R7: halted overflow then halt instruction
        rst_run(1, 0, 2'b00, 1, 0, c);
        set_reg(8'h00);
        halted = 1'b1;
        expect_req(c + 256, 1, "R9 warm request while halted");
        at_cyc(c + 300);
        check(to_flag == 1'b1, "R9 flag set on warm timeout", to_flag, 1);
        pulse_at(c + 350, 4);
        check(to_flag == 1'b0, "R7 halt clears flag", to_flag, 0);
        expect_req(c + 607, 1, "R7 halt restarts count");
        at_cyc(c + 620);
        halted = 1'b0;
        expect_req(c + 863, 0, "R8 chip request after leaving halt");
        at_cyc(c + 880);

        // R6: dual-clear pairing
        rst_run(1, 1, 2'b00, 1, 0, c);
        set_reg(8'h00);
        pulse_at(c + 100, 1);
        pulse_at(c + 150, 0);
        expect_req(c + 256, 0, "R6 half pair and clr_all do not clear");
        pulse_at(c + 300, 2);
        pulse_at(c + 310, 1);
        check(to_flag == 1'b0, "R6 completed pair clears flag", to_flag, 0);
        expect_req(c + 567, 0, "R6 pair b-then-a clears, memory dropped on timeout");
        pulse_at(c + 400, 1);
        pulse_at(c + 410, 1);
        expect_req(c + 823, 0, "R6 repeated clr_a is no pair");
        pulse_at(c + 600, 2);
        pulse_at(c + 610, 2);
        pulse_at(c + 850, 1);
        expect_req(c + 1079, 0, "R6 memory dropped by timeout");
        at_cyc(c + 1090);

        // R10: instruction tick frozen while halted
        rst_run(1, 0, 2'b10, 0, 0, c);
        set_reg(8'h00);
        at_cyc(c + 200);
        halted = 1'b1;
        at_cyc(c + 300);
        halted = 1'b0;
        expect_req(c + 1124, 0, "R10 R4 instruction tick with halt gap");
        at_cyc(c + 1140);

        // R4: RTC source selected
        rst_run(1, 0, 2'b01, 0, 1, c);
        set_reg(8'h00);
        expect_req(c + 256, 0, "R4 rtc source");
        at_cyc(c + 270);

        // R4: unselected strobe ignored
        rst_run(1, 0, 2'b00, 0, 1, c);
        set_reg(8'h00);
        ev0 = n_ev;
        at_cyc(c + 600);
        check(n_ev == ev0, "R4 unselected strobe ignored", n_ev - ev0, 0);

        // R11: disabled
        rst_run(0, 0, 2'b00, 1, 0, c);
        set_reg(8'h00);
        ev0 = n_ev;
        pulse_at(c + 100, 0);
        pulse_at(c + 200, 4);
        at_cyc(c + 700);
        check(n_ev == ev0, "R11 no request when disabled", n_ev - ev0, 0);
        check(to_flag == 1'b0, "R11 flag stays clear", to_flag, 0);

        done = 1'b1;
        finish_run();
    end

endmodule